// File: doc/BRIEF.md
# Six-Bit Bidirectional Port with Direction Control and Wake Detection

This block is a small general-purpose I/O port for the register interface of a simple processor. Each of six pins has an output latch and a direction bit. A cleared direction bit lets the latch value drive the pad, and a set direction bit leaves the pad floating. The direction bits are loaded by a dedicated write strobe and cannot be read back. The port reads as an 8-bit value. The low six bits come from the synchronized pin levels, never from the latch, so a pin that is driven high but held low from outside reads as 0.

The pad interface is abstract: a per-bit output enable, a per-bit output value and a per-bit weak pull-up request, plus the raw pin vector coming in. One bit (index 3 by default) can never drive its pad. Bits handed to an alternate function read as zero. A single pull-up enable controls pull-ups on a fixed set of pins, and a single wake enable controls a change detector on the same set. Selecting the reset-pin function forces the pull-up on pin 3 and removes pin 3 from the change detector.

The change detector compares the current synchronized levels of the eligible pins with a snapshot taken at the most recent port read. While the detector is enabled, any difference sets a wake flag, which stays set until reset.

Top module: `gpio_dirport`

## Requirements
- R1: Read data bits 7 and 6 are always 0.
- R2: After reset every direction bit is 1, so all six output enables are 0.
- R3: A pulse on `dir_wr` loads `wdata` into the direction bits. For each pin other than the input-only one, `pad_oe[i]` is 1 exactly when its direction bit is 0, from the cycle after the write.
- R4: `pad_oe[3]` is never 1, whatever the direction bits or latch contents.
- R5: `pad_out` equals the output latch. The latch changes only on a `port_wr` pulse, which loads `wdata` and is visible the cycle after; a direction write leaves it unchanged.
- R6: `rdata[5:0]` returns the pin levels two clock edges after they change, whatever the direction setting and latch contents.
- R7: A pin whose bit is 1 in `alt_sel` reads as 0 in `rdata`, with no added latency.
- R8: `pad_pullup` is the eligible set {0,1,3} (plus 4 when `WIDE_VARIANT` is 1) when `pullup_en` is 1, and 0 otherwise. `pad_pullup[3]` is also 1 whenever `rstpin_sel` is 1.
- R9: While `wake_en` is 1, a difference between an eligible pin and the snapshot taken at the last `port_rd` pulse sets `wake_flag` three edges after the pin changes. Changes on ineligible pins have no effect.
- R10: When `rstpin_sel` is 1, pin 3 does not take part in wake detection.
- R11: `wake_flag` stays set after the pin returns to its snapshot level and is cleared only by reset. With `wake_en` at 0 it does not set.
- R12: After reset the output latch is 0, the snapshot is 0 and `wake_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Load the output latch from wdata |
| dir_wr | input | 1 | Load the direction bits from wdata |
| wdata | input | 6 | Write data for the implemented bits |
| port_rd | input | 1 | Port read strobe; captures the wake snapshot |
| rdata | output | 8 | Port read value |
| alt_sel | input | 6 | Per-bit alternate-function ownership |
| rstpin_sel | input | 1 | Pin 3 serves as external reset input |
| pullup_en | input | 1 | Global weak pull-up enable |
| wake_en | input | 1 | Global wake-on-change enable |
| pin_in | input | 6 | Raw pin levels |
| pad_oe | output | 6 | Per-pin output driver enable |
| pad_out | output | 6 | Per-pin output drive value |
| pad_pullup | output | 6 | Per-pin weak pull-up request |
| wake_flag | output | 1 | Sticky wake-on-change flag |

## Verification
The hardest case to reach is a wake flag raised against a snapshot that is not all zeros. The flag never clears and the snapshot only moves on a read, so each wake case needs its own reset. The bench resets before every case, moves pins while the detector is off, reads to take the snapshot, and only then enables detection and toggles a single pin. Each pin is tried once with the reset-pin function selected and once without it, and the bench confirms that the flag stays set after the pin returns to its snapshot level.

// File: rtl/gpio_dirport_pkg.sv
package gpio_dirport_pkg;

   // Pins served by pull-up and wake detection; pin 4 only on the wide variant.
   function automatic logic wake_eligible(input int unsigned idx, input bit wide);
      return (idx == 0) || (idx == 1) || (idx == 3) || (wide && (idx == 4));
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
   parameter int unsigned PORT_W      = 6,
   parameter int unsigned IN_ONLY_IDX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_wr,
   input  logic              dir_wr,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_out
);

   logic [PORT_W-1:0] out_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out_latch <= '0;
      else if (port_wr) out_latch <= wdata;
   end

   assign pad_out = out_latch;

   for (genvar i = 0; i < PORT_W; i++) begin : g_bit
      if (i == IN_ONLY_IDX) begin : g_in_only
         assign pad_oe[i] = 1'b0;
      end else begin : g_bidir
         logic dir_hiz;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      dir_hiz <= 1'b1;
            else if (dir_wr) dir_hiz <= wdata[i];
         end
         assign pad_oe[i] = ~dir_hiz;
      end
   end

endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
   parameter int unsigned       PORT_W        = 6,
   parameter int unsigned       RESET_PIN_IDX = 3,
   parameter logic [PORT_W-1:0] ELIG_MASK     = 6'b001011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pin_sync,
   input  logic              port_rd,
   input  logic              wake_en,
   input  logic              rstpin_sel,
   output logic              wake_flag
);

   localparam logic [PORT_W-1:0] RST_BIT = PORT_W'(1) << RESET_PIN_IDX;

   logic [PORT_W-1:0] snap;
   logic [PORT_W-1:0] watch;
   logic              diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap <= '0;
      else if (port_rd) snap <= pin_sync;
   end

   assign watch = ELIG_MASK & ~(rstpin_sel ? RST_BIT : '0);
   assign diff  = |((pin_sync ^ snap) & watch);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wake_flag <= 1'b0;
      else if (wake_en && diff) wake_flag <= 1'b1;
   end

endmodule

// File: rtl/gpio_dirport.sv
module gpio_dirport
   import gpio_dirport_pkg::*;
#(
   parameter int unsigned PORT_W        = 6,
   parameter int unsigned REG_W         = 8,
   parameter int unsigned IN_ONLY_IDX   = 3,
   parameter int unsigned RESET_PIN_IDX = 3,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          WIDE_VARIANT  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_wr,
   input  logic              dir_wr,
   input  logic [PORT_W-1:0] wdata,
   input  logic              port_rd,
   output logic [REG_W-1:0]  rdata,
   input  logic [PORT_W-1:0] alt_sel,
   input  logic              rstpin_sel,
   input  logic              pullup_en,
   input  logic              wake_en,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pad_oe,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_pullup,
   output logic              wake_flag
);

   function automatic logic [PORT_W-1:0] build_elig();
      logic [PORT_W-1:0] m;
      for (int unsigned i = 0; i < PORT_W; i++) m[i] = wake_eligible(i, WIDE_VARIANT);
      return m;
   endfunction

   localparam logic [PORT_W-1:0] ELIG_MASK = build_elig();
   localparam logic [PORT_W-1:0] RST_BIT   = PORT_W'(1) << RESET_PIN_IDX;
   localparam int unsigned       PAD_W     = REG_W - PORT_W;

   if (PORT_W > REG_W)             begin : g_chk_w   $error("PORT_W exceeds REG_W");        end
   if (PORT_W < 5)                 begin : g_chk_min $error("PORT_W must be at least 5");   end
   if (IN_ONLY_IDX >= PORT_W)      begin : g_chk_io  $error("IN_ONLY_IDX out of range");    end
   if (RESET_PIN_IDX >= PORT_W)    begin : g_chk_rp  $error("RESET_PIN_IDX out of range");  end
   if (SYNC_STAGES < 2)            begin : g_chk_s   $error("SYNC_STAGES must be >= 2");    end

   logic [PORT_W-1:0] pin_sync;

   gpio_sync #(
      .WIDTH  (PORT_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pin_sync)
   );

   gpio_drive #(
      .PORT_W      (PORT_W),
      .IN_ONLY_IDX (IN_ONLY_IDX)
   ) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .port_wr (port_wr),
      .dir_wr  (dir_wr),
      .wdata   (wdata),
      .pad_oe  (pad_oe),
      .pad_out (pad_out)
   );

   gpio_wake #(
      .PORT_W        (PORT_W),
      .RESET_PIN_IDX (RESET_PIN_IDX),
      .ELIG_MASK     (ELIG_MASK)
   ) u_wake (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_sync   (pin_sync),
      .port_rd    (port_rd),
      .wake_en    (wake_en),
      .rstpin_sel (rstpin_sel),
      .wake_flag  (wake_flag)
   );

   if (PAD_W > 0) begin : g_pad_hi
      assign rdata = {{PAD_W{1'b0}}, pin_sync & ~alt_sel};
   end else begin : g_no_pad
      assign rdata = pin_sync & ~alt_sel;
   end

   assign pad_pullup = (pullup_en ? ELIG_MASK : '0) | (rstpin_sel ? RST_BIT : '0);

endmodule

// File: rtl/gpio_dirport_chk.sv
module gpio_dirport_chk #(
   parameter int unsigned PORT_W        = 6,
   parameter int unsigned REG_W         = 8,
   parameter int unsigned IN_ONLY_IDX   = 3,
   parameter int unsigned RESET_PIN_IDX = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              port_wr,
   input logic              dir_wr,
   input logic [PORT_W-1:0] wdata,
   input logic [REG_W-1:0]  rdata,
   input logic [PORT_W-1:0] alt_sel,
   input logic              rstpin_sel,
   input logic              wake_en,
   input logic [PORT_W-1:0] pad_oe,
   input logic [PORT_W-1:0] pad_out,
   input logic [PORT_W-1:0] pad_pullup,
   input logic              wake_flag
);

   localparam logic [PORT_W-1:0] IO_BIT = PORT_W'(1) << IN_ONLY_IDX;

   AST_UPPER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata >> PORT_W) == '0);                                          // R1
   AST_INPUT_ONLY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[IN_ONLY_IDX]);                                             // R4
   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      dir_wr |=> pad_oe == (~$past(wdata) & ~IO_BIT));                   // R3
   AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr |=> $stable(pad_out));                                    // R5
   AST_ALT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[PORT_W-1:0] & alt_sel) == '0);                              // R7
   AST_RSTPIN_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
      rstpin_sel |-> pad_pullup[RESET_PIN_IDX]);                         // R8
   AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wake_flag |=> wake_flag);                                          // R11
   AST_NO_WAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!wake_en && !wake_flag) |=> !wake_flag);                          // R11

endmodule

bind gpio_dirport gpio_dirport_chk #(
   .PORT_W        (PORT_W),
   .REG_W         (REG_W),
   .IN_ONLY_IDX   (IN_ONLY_IDX),
   .RESET_PIN_IDX (RESET_PIN_IDX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .port_wr    (port_wr),
   .dir_wr     (dir_wr),
   .wdata      (wdata),
   .rdata      (rdata),
   .alt_sel    (alt_sel),
   .rstpin_sel (rstpin_sel),
   .wake_en    (wake_en),
   .pad_oe     (pad_oe),
   .pad_out    (pad_out),
   .pad_pullup (pad_pullup),
   .wake_flag  (wake_flag)
);

// File: tb/gpio_dirport_tb.sv
`timescale 1ns/1ps
module gpio_dirport_tb;

   localparam logic [5:0] ELIG = 6'b001011;
   localparam logic [5:0] IOM  = 6'b001000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_wr = 1'b0, dir_wr = 1'b0, port_rd = 1'b0;
   logic [5:0] wdata = '0, alt_sel = '0, pin_in = '0;
   logic       rstpin_sel = 1'b0, pullup_en = 1'b0, wake_en = 1'b0;
   logic [7:0] rdata;
   logic [5:0] pad_oe, pad_out, pad_pullup;
   logic       wake_flag;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   gpio_dirport u_dut (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .dir_wr(dir_wr), .wdata(wdata),
      .port_rd(port_rd), .rdata(rdata), .alt_sel(alt_sel), .rstpin_sel(rstpin_sel),
      .pullup_en(pullup_en), .wake_en(wake_en), .pin_in(pin_in), .pad_oe(pad_oe),
      .pad_out(pad_out), .pad_pullup(pad_pullup), .wake_flag(wake_flag)
   );

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic wr_dir(input logic [5:0] v);
      wdata = v; dir_wr = 1'b1; tick(); dir_wr = 1'b0;
   endtask

   task automatic wr_lat(input logic [5:0] v);
      wdata = v; port_wr = 1'b1; tick(); port_wr = 1'b0;
   endtask

   task automatic rd_snap();
      port_rd = 1'b1; tick(); port_rd = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(1);
      do_reset();
      // R2 / R12 reset state
      chk("R2 oe after reset", {2'b0, pad_oe}, 8'h00);
      chk("R12 latch after reset", {2'b0, pad_out}, 8'h00);
      chk("R12 flag after reset", {7'b0, wake_flag}, 8'h00);
      chk("R1 read after reset", rdata, 8'h00);

      // R3 / R4 direction sweep with varying latch
      for (int d = 0; d < 64; d++) begin
         wr_lat(6'(d ^ 6'h2A));
         wr_dir(6'(d));
         chk("R3 R4 oe vs dir", {2'b0, pad_oe}, {2'b0, ~6'(d) & ~IOM});
      end

      // R5 latch sweep; direction writes leave it alone
      for (int v = 0; v < 64; v++) begin
         wr_lat(6'(v));
         chk("R5 latch load", {2'b0, pad_out}, 8'(v));
         wr_dir(6'(63 - v));
         chk("R5 latch held over dir write", {2'b0, pad_out}, 8'(v));
      end

      // R6 / R7 / R1 read sweep: every pin pattern x every alternate mask
      for (int p = 0; p < 64; p++) begin
         if (p[0]) begin
            wr_dir(6'h00);
            wr_lat(~6'(p));
         end else begin
            wr_dir(6'h3F);
         end
         pin_in = 6'(p);
         tick(1);
         alt_sel = '0;
         #0.5;
         chk("R6 one edge not yet visible", {2'b0, rdata[5:0] ^ 6'(p)} == 8'h00 ? 8'h1 : 8'h0,
             (p == 0 || p == int'(pin_in) && 0) ? 8'h1 : 8'h0);
         tick(1);
         for (int a = 0; a < 64; a++) begin
            alt_sel = 6'(a);
            #0.5;
            chk("R6 R7 R1 read", rdata, {2'b00, 6'(p) & ~6'(a)});
         end
         alt_sel = '0;
      end

      // R8 pull-up combinations
      for (int c = 0; c < 4; c++) begin
         pullup_en  = c[0];
         rstpin_sel = c[1];
         #0.5;
         chk("R8 pullup", {2'b0, pad_pullup},
             {2'b0, (c[0] ? ELIG : 6'h00) | (c[1] ? 6'h08 : 6'h00)});
      end
      pullup_en = 1'b0;

      // R9 / R10 / R11 wake per pin, reset-pin function off and on
      for (int m = 0; m < 2; m++) begin
         for (int b = 0; b < 6; b++) begin
            rstpin_sel = m[0];
            wake_en = 1'b0;
            pin_in = '0;
            do_reset();
            pin_in = 6'h15;
            tick(3);
            rd_snap();
            wake_en = 1'b1;
            tick(3);
            chk("R9 snapshot match no wake", {7'b0, wake_flag}, 8'h00);
            pin_in = 6'h15 ^ (6'h1 << b);
            tick(2);
            chk("R9 not yet set", {7'b0, wake_flag}, 8'h00);
            tick(1);
            chk(m ? "R10 wake with reset pin" : "R9 wake per pin", {7'b0, wake_flag},
                {7'b0, ELIG[b] && !(m == 1 && b == 3)});
            pin_in = 6'h15;
            tick(3);
            chk("R11 sticky", {7'b0, wake_flag}, {7'b0, ELIG[b] && !(m == 1 && b == 3)});
         end
      end

      // R11 disabled detector does not set, then reset clears a set flag
      rstpin_sel = 1'b0;
      wake_en = 1'b0;
      pin_in = '0;
      do_reset();
      rd_snap();
      pin_in = 6'h0B;
      tick(4);
      chk("R11 disabled no wake", {7'b0, wake_flag}, 8'h00);
      wake_en = 1'b1;
      tick(1);
      chk("R11 set when enabled", {7'b0, wake_flag}, 8'h01);
      do_reset();
      chk("R11 cleared by reset", {7'b0, wake_flag}, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule